// File: doc/BRIEF.md
# Colour Palette DAC Register Block

This block holds a 256-entry colour lookup table, with an 8-bit red, green and blue value in each entry, together with the small register interface that software uses to load it. The host writes 32-bit words into a 16-byte register window. One register selects the palette entry. A second register receives the colour components one after another, and each component is taken from the top byte of the written word.

A three-step phase machine steers the successive colour writes to red, then green, then blue. After the blue write the entry index moves on to the next entry by itself, so a whole table can be streamed after a single index write.

The display side presents an 8-bit pixel value on a lookup port. One clock later it receives the 24-bit colour of that entry. Host reads of the register window always return zero.

Top module: `palette_dac`

## Requirements
- R1: A write with all four byte strobes set to window offset 0x0 loads the entry index from `wr_data[31:24]` and returns the colour phase to red.
- R2: Successive full-word writes to offset 0x4 store `wr_data[31:24]` into the red, then the green, then the blue component of the currently indexed entry, and the phase moves on after each of these writes.
- R3: After the blue write the index increments modulo 256 (255 wraps to 0) and the phase returns to red.
- R4: A write to any offset other than 0x0 or 0x4, or any write with `wr_be` other than 4'hF, changes neither the index, nor the phase, nor any palette entry.
- R5: `host_rdata` is zero at all times.
- R6: After reset every entry is black (0,0,0) except entry 255, which is white (255,255,255), and the index and phase are cleared (index 0, phase red).
- R7: `pix_rgb` is registered and carries {red[23:16], green[15:8], blue[7:0]} of the entry that `pix_idx` selected on the previous rising edge. A colour write is visible to lookups from the following edge onward, so a lookup of the same entry in the same cycle as the write returns the old colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Byte offset inside the register window |
| wr_be | input | 4 | Byte strobes; only 4'hF is accepted |
| wr_data | input | 32 | Host write data; the colour and index values are in bits [31:24] |
| host_rdata | output | 32 | Host read data, always zero |
| pix_idx | input | 8 | Pixel value to look up |
| pix_rgb | output | 24 | Colour of the looked-up entry, one cycle later |

## Verification
A wrong phase value puts the next component into the wrong colour channel. The fault shows on `pix_rgb` one cycle after a lookup of the entry that was written. A wrong index after the blue write, after a wrap or after an ignored access lands the next colour in another entry, so the bench reads back both the intended entry and its neighbours. Writes that should be ignored are followed by a complete colour triple, so any hidden change to the phase becomes visible as misplaced components. The reset contents are read from entry 255 and from an ordinary entry before any write.

// File: rtl/palette_dac.sv
module palette_dac #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int COMP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W/8-1:0]     wr_be,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [DATA_W-1:0]       host_rdata,
  input  logic [COMP_W-1:0]       pix_idx,
  output logic [3*COMP_W-1:0]     pix_rgb
);
  localparam int DEPTH = 1 << COMP_W;
  localparam int BE_W  = DATA_W / 8;
  localparam int RGB_W = 3 * COMP_W;
  localparam logic [ADDR_W-1:0] OFF_INDEX = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_COLOR = ADDR_W'(4);
  localparam logic [1:0] PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2;

  logic [RGB_W-1:0]  pal [DEPTH];
  logic [COMP_W-1:0] idx;
  logic [1:0]        phase;

  wire              full_wr  = wr_en && (wr_be == {BE_W{1'b1}});
  wire              idx_wr   = full_wr && (wr_addr == OFF_INDEX);
  wire              col_wr   = full_wr && (wr_addr == OFF_COLOR);
  wire [COMP_W-1:0] wr_byte  = wr_data[DATA_W-1 -: COMP_W];
  wire              unused_low = ^wr_data[DATA_W-COMP_W-1:0];

  assign host_rdata = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (idx_wr) begin
      idx   <= wr_byte;
      phase <= PH_RED;
    end else if (col_wr) begin
      case (phase)
        PH_GRN:  phase <= PH_BLU;
        PH_BLU: begin
          phase <= PH_RED;
          idx   <= idx + 1'b1;
        end
        default: phase <= PH_GRN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        pal[i] <= (i == DEPTH - 1) ? {RGB_W{1'b1}} : '0;
    end else if (col_wr) begin
      case (phase)
        PH_GRN:  pal[idx][COMP_W +: COMP_W]   <= wr_byte;
        PH_BLU:  pal[idx][0 +: COMP_W]        <= wr_byte;
        default: pal[idx][2*COMP_W +: COMP_W] <= wr_byte;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_rgb <= '0;
    else        pix_rgb <= pal[pix_idx];
  end

  a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (idx == $past(wr_byte)) && (phase == PH_RED));

  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (col_wr && phase == PH_RED) |=> (phase == PH_GRN) && $stable(idx));

  a_r3_index_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (col_wr && phase == PH_BLU) |=> (idx == COMP_W'($past(idx) + 1)) && (phase == PH_RED));

  a_r4_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !idx_wr && !col_wr) |=> $stable(idx) && $stable(phase));

  a_r5_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata == '0);
endmodule

// File: tb/tb_palette_dac.sv
module tb_palette_dac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] host_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  palette_dac dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .host_rdata(host_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb));

  // {op(0=write,1=read), addr, be, data, expected rgb}; reads use data[31:24] as pixel index
  localparam int NV = 24;
  localparam logic [67:0] VEC [NV] = '{
    {4'h0, 4'h0, 4'hF, 32'h10AB_CDEF, 24'h0},      // R1 index 16
    {4'h0, 4'h4, 4'hF, 32'h1100_0000, 24'h0},      // R2 red
    {4'h0, 4'h4, 4'hF, 32'h22FF_FFFF, 24'h0},      // R2 green
    {4'h0, 4'h4, 4'hF, 32'h3300_0000, 24'h0},      // R2 blue, R3 index 17
    {4'h0, 4'h4, 4'hF, 32'h4400_0000, 24'h0},      // R3 red of 17
    {4'h1, 4'h0, 4'h0, 32'h1000_0000, 24'h112233}, // R2 entry 16
    {4'h0, 4'h4, 4'hF, 32'h5500_0000, 24'h0},
    {4'h0, 4'h4, 4'hF, 32'h6600_0000, 24'h0},      // index 18
    {4'h1, 4'h0, 4'h0, 32'h1100_0000, 24'h445566}, // R3 entry 17
    {4'h0, 4'h0, 4'hF, 32'h2000_0000, 24'h0},      // R1 index 32
    {4'h0, 4'h4, 4'hF, 32'h7700_0000, 24'h0},      // red of 32
    {4'h0, 4'h0, 4'hF, 32'h3000_0000, 24'h0},      // R1 mid-triple: index 48, phase red
    {4'h0, 4'h4, 4'hF, 32'h8800_0000, 24'h0},
    {4'h0, 4'h4, 4'hF, 32'h9900_0000, 24'h0},
    {4'h0, 4'h4, 4'hF, 32'hAA00_0000, 24'h0},      // index 49
    {4'h1, 4'h0, 4'h0, 32'h2000_0000, 24'h770000}, // R1 entry 32 kept only red
    {4'h1, 4'h0, 4'h0, 32'h3000_0000, 24'h8899AA}, // R1 entry 48
    {4'h0, 4'h8, 4'hF, 32'hEE00_0000, 24'h0},      // R4 other offset
    {4'h0, 4'h4, 4'h7, 32'hEE00_0000, 24'h0},      // R4 partial strobe
    {4'h0, 4'hC, 4'hF, 32'h0000_0000, 24'h0},      // R4 other offset
    {4'h0, 4'h4, 4'hF, 32'hBB00_0000, 24'h0},
    {4'h0, 4'h4, 4'hF, 32'hCC00_0000, 24'h0},
    {4'h0, 4'h4, 4'hF, 32'hDD00_0000, 24'h0},
    {4'h1, 4'h0, 4'h0, 32'h3100_0000, 24'hBBCCDD}  // R4 nothing moved index or phase
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic do_rd(input logic [7:0] i, input logic [23:0] exp, input string req);
    pix_idx = i;
    @(negedge clk);
    check(req, {8'h0, pix_rgb}, {8'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R6 pix_rgb in reset", {8'h0, pix_rgb}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    do_rd(8'd255, 24'hFFFFFF, "R6 entry 255 white");
    do_rd(8'd5,   24'h000000, "R6 entry 5 black");
    check("R5 host_rdata", host_rdata, 32'h0);
    // R6: index 0 and phase red after reset
    do_wr(4'h4, 4'hF, 32'h0100_0000);
    do_wr(4'h4, 4'hF, 32'h0200_0000);
    do_wr(4'h4, 4'hF, 32'h0300_0000);
    do_rd(8'd0, 24'h010203, "R6 index and phase cleared");

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][67:64] == 4'h0)
        do_wr(VEC[v][63:60], VEC[v][59:56], VEC[v][55:24]);
      else
        do_rd(VEC[v][55:48], VEC[v][23:0], $sformatf("R2 table vector %0d", v));
      check("R5 host_rdata zero", host_rdata, 32'h0);
    end

    // R3 wrap 255 -> 0
    do_wr(4'h0, 4'hF, 32'hFF00_0000);
    do_wr(4'h4, 4'hF, 32'h0A00_0000);
    do_wr(4'h4, 4'hF, 32'h0B00_0000);
    do_wr(4'h4, 4'hF, 32'h0C00_0000);
    do_wr(4'h4, 4'hF, 32'h5A00_0000);
    do_rd(8'd255, 24'h0A0B0C, "R3 entry 255 written");
    do_rd(8'd0,   24'h5A0203, "R3 wrap to entry 0");

    // R7 same-cycle write and lookup
    do_wr(4'h0, 4'hF, 32'h6400_0000);
    do_wr(4'h4, 4'hF, 32'h1200_0000);
    do_wr(4'h4, 4'hF, 32'h3400_0000);
    pix_idx = 8'd100;
    do_wr(4'h4, 4'hF, 32'h5600_0000);
    check("R7 same-cycle old value", {8'h0, pix_rgb}, 32'h0012_3400);
    @(negedge clk);
    check("R7 new value next edge", {8'h0, pix_rgb}, 32'h0012_3456);

    // R6 reset again restores contents
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_rd(8'd100, 24'h000000, "R6 re-reset entry 100");
    do_rd(8'd255, 24'hFFFFFF, "R6 re-reset entry 255");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule